// File: doc/BRIEF.md
# Power Button Sleep Controller

This block watches an active-low power button and turns its presses into requests to enter or leave low-power states. The raw pin is idle high. It is synchronised and then debounced, so a change of level counts only after it has held steady for a programmable interval. A debounced press is then read against the system's present power state. In the working state it raises a one-cycle request to go to sleep. In any sleeping or off state it raises a one-cycle wake event instead.

If the button is kept down for the long-hold interval, counted from the accepted press, the block issues a single forced-off pulse. The power sequencer takes this pulse as an unconditional order to go to soft-off. The pulse fires in every state, deep sleep included. Once it has fired, the block ignores the button until a debounced release is seen. All intervals are given in milliseconds together with the clock frequency and are counted in clock cycles. A status output shows the debounced button level.

Top module: `power_button_sleep_ctl`

## Requirements
- R1: A change of the raw button level is accepted only after the synchronised level has differed from the accepted level for DEB_CYC = CLK_HZ*DEBOUNCE_MS/1000 consecutive cycles. An accepted press shows at the outputs SYNC_STAGES+DEB_CYC cycles after the raw pin falls. Shorter glitches in either direction have no effect.
- R2: An accepted press while the power state input is 2'b00 (working) gives exactly one sleepReq pulse, one cycle long, and no wakeEvt.
- R3: An accepted press while the power state input is 2'b01, 2'b10 or 2'b11 (the sleep and soft-off codes) gives exactly one wakeEvt pulse, one cycle long, and no sleepReq.
- R4: If the button stays down, forceOff pulses for one cycle exactly HOLD_CYC = CLK_HZ*HOLD_MS/1000 cycles after the press pulse. This happens whatever the power state is, including 2'b01 and 2'b10.
- R5: A debounced release before the hold interval ends produces no forceOff. The next press restarts the hold interval from zero.
- R6: At most one forceOff is issued per hold. No new press is recognised until a debounced release has been seen.
- R7: buttonDown reflects the debounced level (1 = pressed). After reset all outputs are 0.
- R8: sleepReq, wakeEvt and forceOff are never high in the same cycle, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| buttonN | input | 1 | Raw button pin, low when pressed |
| sleepState | input | 2 | Present power state: 00 working, 01 light sleep, 10 deep sleep, 11 soft-off |
| sleepReq | output | 1 | One-cycle request to enter a sleep state |
| wakeEvt | output | 1 | One-cycle wake event |
| forceOff | output | 1 | One-cycle unconditional soft-off order |
| buttonDown | output | 1 | Debounced button level, 1 when pressed |

## Verification
Some properties are checked by assertions on every cycle. A sleep request only follows a working-state sample and a wake event only follows a non-working one. The pulses are mutually exclusive and one cycle wide. Every pulse coincides with a debounced pressed level, and a second override cannot occur within one hold. Other behaviours depend on exact cycle counts, so only the bench scenarios show them: glitches shorter than the debounce window are rejected, the press latency through synchroniser and filter is exact, the override lands precisely at the hold interval, and an early release cancels the override.

// File: rtl/pbsc_pkg.sv
package pbsc_pkg;

  // Power state codes presented by the system.
  typedef enum logic [1:0] {
    PWR_WORK  = 2'b00,
    PWR_LIGHT = 2'b01,
    PWR_DEEP  = 2'b10,
    PWR_OFF   = 2'b11
  } pwr_state_e;

  // Control-to-datapath strobes for the hold timer.
  typedef struct packed {
    logic holdClr;
    logic holdRun;
  } dp_ctrl_t;

  // Press handling phases.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'b00,
    PH_HELD   = 2'b01,
    PH_LOCKED = 2'b10
  } press_phase_e;

endpackage

// File: rtl/pbsc_datapath.sv
module pbsc_datapath
  import pbsc_pkg::*;
#(
  parameter int unsigned          SYNC_STAGES = 2,
  parameter longint unsigned      DEB_CYC     = 16,
  parameter longint unsigned      HOLD_CYC    = 4000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     buttonN,
  input  dp_ctrl_t ctrl,
  output logic     pressAcc,
  output logic     releaseAcc,
  output logic     buttonDown,
  output logic     holdDone
);

  localparam int unsigned DEB_W  = (DEB_CYC  > 1) ? $clog2(DEB_CYC)  : 1;
  localparam int unsigned HOLD_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [DEB_W-1:0]  DEB_LAST  = DEB_W'(DEB_CYC - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);

  // Synchroniser chain, reset to the idle (high) level.
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rawDown;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= buttonN;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], buttonN};
      end
    end
  endgenerate

  assign rawDown = ~syncQ[SYNC_STAGES-1];

  // Debounce filter: accept a level after DEB_CYC cycles of disagreement.
  logic [DEB_W-1:0] debCnt;
  logic             downQ;
  logic             mismatch;
  logic             flip;

  assign mismatch = (rawDown != downQ);
  assign flip     = mismatch && (debCnt == DEB_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      debCnt <= '0;
      downQ  <= 1'b0;
    end else if (!mismatch) begin
      debCnt <= '0;
    end else if (flip) begin
      debCnt <= '0;
      downQ  <= rawDown;
    end else begin
      debCnt <= debCnt + 1'b1;
    end
  end

  assign pressAcc   = flip &  rawDown;
  assign releaseAcc = flip & ~rawDown;
  assign buttonDown = downQ;

  // Hold timer, started and cleared by the control strobes.
  logic [HOLD_W-1:0] holdCnt;

  assign holdDone = ctrl.holdRun && (holdCnt == HOLD_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (ctrl.holdClr) begin
      holdCnt <= '0;
    end else if (ctrl.holdRun && !holdDone) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

endmodule

// File: rtl/pbsc_control.sv
module pbsc_control
  import pbsc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pressAcc,
  input  logic       releaseAcc,
  input  logic       holdDone,
  input  logic [1:0] sleepState,
  output dp_ctrl_t   ctrl,
  output logic       sleepReq,
  output logic       wakeEvt,
  output logic       forceOff
);

  press_phase_e phaseQ, phaseNext;
  logic         sleepNext, wakeNext, forceNext;
  logic         isWorking;

  assign isWorking = (pwr_state_e'(sleepState) == PWR_WORK);

  always_comb begin
    phaseNext    = phaseQ;
    sleepNext    = 1'b0;
    wakeNext     = 1'b0;
    forceNext    = 1'b0;
    ctrl.holdClr = (phaseQ == PH_IDLE);
    ctrl.holdRun = (phaseQ == PH_HELD);
    unique case (phaseQ)
      PH_IDLE: begin
        if (pressAcc) begin
          sleepNext = isWorking;
          wakeNext  = !isWorking;
          phaseNext = PH_HELD;
        end
      end
      PH_HELD: begin
        if (releaseAcc) begin
          phaseNext = PH_IDLE;
        end else if (holdDone) begin
          forceNext = 1'b1;
          phaseNext = PH_LOCKED;
        end
      end
      PH_LOCKED: begin
        if (releaseAcc) phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ   <= PH_IDLE;
      sleepReq <= 1'b0;
      wakeEvt  <= 1'b0;
      forceOff <= 1'b0;
    end else begin
      phaseQ   <= phaseNext;
      sleepReq <= sleepNext;
      wakeEvt  <= wakeNext;
      forceOff <= forceNext;
    end
  end

endmodule

// File: rtl/power_button_sleep_ctl.sv
module power_button_sleep_ctl
  import pbsc_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 100_000_000,
  parameter longint unsigned DEBOUNCE_MS = 16,
  parameter longint unsigned HOLD_MS     = 4000,
  parameter int unsigned     SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       buttonN,
  input  logic [1:0] sleepState,
  output logic       sleepReq,
  output logic       wakeEvt,
  output logic       forceOff,
  output logic       buttonDown
);

  localparam longint unsigned DEB_RAW  = CLK_HZ * DEBOUNCE_MS / 1000;
  localparam longint unsigned HOLD_RAW = CLK_HZ * HOLD_MS / 1000;
  localparam longint unsigned DEB_CYC  = (DEB_RAW  == 0) ? 1 : DEB_RAW;
  localparam longint unsigned HOLD_CYC = (HOLD_RAW == 0) ? 1 : HOLD_RAW;

  dp_ctrl_t ctrl;
  logic     pressAcc, releaseAcc, holdDone;

  pbsc_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .DEB_CYC     (DEB_CYC),
    .HOLD_CYC    (HOLD_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .buttonN    (buttonN),
    .ctrl       (ctrl),
    .pressAcc   (pressAcc),
    .releaseAcc (releaseAcc),
    .buttonDown (buttonDown),
    .holdDone   (holdDone)
  );

  pbsc_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .pressAcc   (pressAcc),
    .releaseAcc (releaseAcc),
    .holdDone   (holdDone),
    .sleepState (sleepState),
    .ctrl       (ctrl),
    .sleepReq   (sleepReq),
    .wakeEvt    (wakeEvt),
    .forceOff   (forceOff)
  );

endmodule

// File: rtl/pbsc_checker.sv
module pbsc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       buttonN,
  input logic [1:0] sleepState,
  input logic       sleepReq,
  input logic       wakeEvt,
  input logic       forceOff,
  input logic       buttonDown
);

  // Tracks whether an override already fired during the present hold.
  logic overrideSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            overrideSeen <= 1'b0;
    else if (forceOff)    overrideSeen <= 1'b1;
    else if (!buttonDown) overrideSeen <= 1'b0;
  end

  a_r2_sleep_from_work: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |-> $past(sleepState) == 2'b00);

  a_r3_wake_from_sleep: assert property (@(posedge clk) disable iff (!rstN)
    wakeEvt |-> $past(sleepState) != 2'b00);

  a_r7_press_needs_down: assert property (@(posedge clk) disable iff (!rstN)
    (sleepReq || wakeEvt) |-> buttonDown);

  a_r4_force_needs_down: assert property (@(posedge clk) disable iff (!rstN)
    forceOff |-> buttonDown);

  a_r6_one_override: assert property (@(posedge clk) disable iff (!rstN)
    forceOff |-> !overrideSeen);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sleepReq, wakeEvt, forceOff}));

  a_r8_sleep_width: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> !sleepReq);

  a_r8_wake_width: assert property (@(posedge clk) disable iff (!rstN)
    wakeEvt |=> !wakeEvt);

  a_r8_force_width: assert property (@(posedge clk) disable iff (!rstN)
    forceOff |=> !forceOff);

endmodule

bind power_button_sleep_ctl pbsc_checker u_chk (.*);

// File: tb/power_button_sleep_ctl_bench.sv
module power_button_sleep_ctl_bench;

  localparam longint unsigned CLK_HZ = 1000;
  localparam longint unsigned DEB_MS = 16;
  localparam longint unsigned HLD_MS = 4000;
  localparam int SYNC = 2;
  localparam int DEB  = int'(CLK_HZ * DEB_MS / 1000);
  localparam int HOLD = int'(CLK_HZ * HLD_MS / 1000);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic buttonN = 1'b1;
  logic [1:0] sleepState = 2'b00;
  logic sleepReq, wakeEvt, forceOff, buttonDown;

  always #2.5 clk = ~clk;

  power_button_sleep_ctl #(
    .CLK_HZ(CLK_HZ), .DEBOUNCE_MS(DEB_MS), .HOLD_MS(HLD_MS), .SYNC_STAGES(SYNC)
  ) u_power_button_sleep_ctl (
    .clk(clk), .rstN(rstN), .buttonN(buttonN), .sleepState(sleepState),
    .sleepReq(sleepReq), .wakeEvt(wakeEvt), .forceOff(forceOff),
    .buttonDown(buttonDown)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycle counter advances on rising edges; monitors sample on falling edges.
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nSleep = 0, nWake = 0, nForce = 0, nClash = 0, nWide = 0;
  int lastPressCyc = 0, lastForceCyc = 0;
  logic prevS = 0, prevW = 0, prevF = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (sleepReq) begin nSleep++; lastPressCyc = cyc; end
      if (wakeEvt)  begin nWake++;  lastPressCyc = cyc; end
      if (forceOff) begin nForce++; lastForceCyc = cyc; end
      if (int'(sleepReq) + int'(wakeEvt) + int'(forceOff) > 1) nClash++;
      if ((sleepReq && prevS) || (wakeEvt && prevW) || (forceOff && prevF)) nWide++;
      prevS = sleepReq; prevW = wakeEvt; prevF = forceOff;
    end
  end

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  st;
    logic [15:0] hold;
    logic        s;
    logic        w;
    logic        f;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 16'd10,   1'b0, 1'b0, 1'b0},  // R1 short glitch ignored
    '{2'b00, 16'd40,   1'b1, 1'b0, 1'b0},  // R2 working -> sleep request
    '{2'b01, 16'd40,   1'b0, 1'b1, 1'b0},  // R3 light sleep -> wake
    '{2'b10, 16'd40,   1'b0, 1'b1, 1'b0},  // R3 deep sleep -> wake
    '{2'b11, 16'd40,   1'b0, 1'b1, 1'b0},  // R3 soft-off -> wake
    '{2'b00, 16'd4100, 1'b1, 1'b0, 1'b1},  // R4 override from working
    '{2'b01, 16'd4100, 1'b0, 1'b1, 1'b1},  // R4 override from light sleep
    '{2'b10, 16'd4100, 1'b0, 1'b1, 1'b1},  // R4 override from deep sleep
    '{2'b00, 16'd3000, 1'b1, 1'b0, 1'b0},  // R5 early release
    '{2'b00, 16'd9000, 1'b1, 1'b0, 1'b1}   // R6 one override per hold
  };

  initial begin
    int s0, w0, f0, t0;
    // R7 reset state
    waitCyc(3);
    chk({sleepReq, wakeEvt, forceOff, buttonDown} == 4'b0, "R7 reset outputs",
        int'({sleepReq, wakeEvt, forceOff, buttonDown}), 0);
    @(negedge clk) rstN = 1'b1;
    waitCyc(5);
    chk(buttonDown == 1'b0, "R7 idle level", int'(buttonDown), 0);

    for (int v = 0; v < NV; v++) begin
      s0 = nSleep; w0 = nWake; f0 = nForce;
      sleepState = VECS[v].st;
      buttonN = 1'b0;
      waitCyc(int'(VECS[v].hold));
      buttonN = 1'b1;
      waitCyc(DEB + SYNC + 8);
      chk(nSleep - s0 == int'(VECS[v].s), $sformatf("R2 vec%0d sleepReq count", v), nSleep - s0, int'(VECS[v].s));
      chk(nWake - w0 == int'(VECS[v].w), $sformatf("R3 vec%0d wakeEvt count", v), nWake - w0, int'(VECS[v].w));
      chk(nForce - f0 == int'(VECS[v].f), $sformatf("R4 vec%0d forceOff count", v), nForce - f0, int'(VECS[v].f));
    end

    // R1 press latency and R7 status while held / after release
    sleepState = 2'b00;
    buttonN = 1'b0;
    t0 = cyc;
    waitCyc(DEB + SYNC + 4);
    chk(lastPressCyc - t0 == SYNC + DEB, "R1 press latency", lastPressCyc - t0, SYNC + DEB);
    chk(buttonDown == 1'b1, "R7 held level", int'(buttonDown), 1);
    // R4 override timing, with state changed mid-hold to deep sleep
    sleepState = 2'b10;
    waitCyc(HOLD);
    chk(lastForceCyc - lastPressCyc == HOLD, "R4 override delay", lastForceCyc - lastPressCyc, HOLD);
    buttonN = 1'b1;
    waitCyc(DEB + SYNC + 4);
    chk(buttonDown == 1'b0, "R7 released level", int'(buttonDown), 0);

    // R1 release glitch during a hold does not cancel it or re-press
    s0 = nSleep; f0 = nForce;
    sleepState = 2'b00;
    buttonN = 1'b0;
    waitCyc(1000);
    buttonN = 1'b1;
    waitCyc(DEB - 4);
    buttonN = 1'b0;
    waitCyc(3200);
    buttonN = 1'b1;
    waitCyc(DEB + SYNC + 8);
    chk(nSleep - s0 == 1, "R1 glitch no re-press", nSleep - s0, 1);
    chk(nForce - f0 == 1, "R1 glitch keeps hold", nForce - f0, 1);

    // R5 hold restarts: two 3000-cycle presses never sum to an override
    f0 = nForce;
    for (int k = 0; k < 2; k++) begin
      buttonN = 1'b0; waitCyc(3000);
      buttonN = 1'b1; waitCyc(DEB + SYNC + 8);
    end
    chk(nForce - f0 == 0, "R5 hold restarts", nForce - f0, 0);

    // R8 exclusivity and width over the whole run
    chk(nClash == 0, "R8 pulses exclusive", nClash, 0);
    chk(nWide == 0, "R8 single-cycle pulses", nWide, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    waitCyc(150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule